// File: doc/BRIEF.md
# Single-Fetch Page Table Refill Engine

This block services translation misses for a TLB whose page table is a flat, virtually addressed array. When an instruction-side or data-side access misses, the engine computes the address of the one 4-byte entry that describes the missing 4 KiB page. The address is a table base value plus the missing page number times four. The table spans 4 MiB of virtual space: 1024 pages, each holding 1024 entries.

The engine sends that entry address back through the TLB lookup port at ring 0 privilege, because the table itself lives in virtual space. If the lookup hits, the engine issues exactly one memory read to the translated physical address. It writes the returned word into the automatically managed 4-way bank, then pulses a restart so the original access retries. Each set keeps its own round-robin victim pointer, one for each side.

If the lookup of the entry address misses, no deeper walk follows. The engine raises an instruction-side or data-side TLB-miss exception. It raises a double exception instead when the exception-mode flag is already set. A read error on the entry fetch is reported as a data-access fault. The engine handles one miss at a time.

Top module: `pte_refill_engine`

## Requirements
- R1: The entry address presented on `lkup_vaddr` equals `pt_base + {miss_vpn, 2'b00}`, zero-extended: the missing virtual address shifted right by 10 with its two low bits cleared. This holds up to the last page number of the table.
- R2: Each accepted miss gives exactly one lookup, with `lkup_ring` = 0. When the lookup hits, the memory read goes to the returned `lkup_paddr`.
- R3: A successful refill issues exactly one memory read. `mem_req` and `mem_addr` hold steady until `mem_ack`, and `mem_req` drops in the cycle after the acknowledge.
- R4: When the entry lookup misses, the engine pulses `exc_valid` with `exc_code` 1 for an instruction-side miss (`miss_ifetch`=1) or 2 for a data-side miss. No memory read and no fill follow.
- R5: When `excm` is 1 at the time the entry lookup misses, `exc_code` is 3 (double exception), whichever side missed.
- R6: After a successful read, `fill_valid` pulses for one cycle. It carries `fill_pte` = the read word, `fill_vpn` = the missing page number, `fill_ifetch` = the side and `fill_way` = the victim. `restart` pulses in the next cycle. No exception is raised.
- R7: Each set (`miss_vpn[SETS_LOG2-1:0]`) has a victim pointer per side. The pointer starts at way 0 and steps 0,1,2,3,0 with each fill to that set and side. Other sets and the other side are left unchanged.
- R8: `busy` rises in the cycle after a miss is accepted and falls after the last pulse (`restart` or `exc_valid`). A `miss_valid` raised while busy is ignored: it causes no second read or fill.
- R9: A memory read that returns `mem_err`=1 raises `exc_code` 4 (data-access fault) with no fill and no restart.
- R10: After reset, `busy`, `lkup_req`, `mem_req`, `fill_valid`, `restart` and `exc_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Original access missed; accepted when idle |
| miss_vpn | input | VA_W-12 | Page number of the missing access |
| miss_ifetch | input | 1 | 1 = instruction side, 0 = data side |
| excm | input | 1 | Exception-mode flag |
| pt_base | input | VA_W | Virtual base of the linear page table |
| busy | output | 1 | A miss is in service |
| lkup_req | output | 1 | Translate the entry address |
| lkup_vaddr | output | VA_W | Entry virtual address |
| lkup_ring | output | 2 | Privilege ring of the lookup (always 0) |
| lkup_hit | input | 1 | Lookup hit, same cycle |
| lkup_paddr | input | PA_W | Translated entry address |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | PA_W | Entry physical address |
| mem_ack | input | 1 | Read complete |
| mem_err | input | 1 | Read failed, valid with `mem_ack` |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |
| fill_valid | output | 1 | Write entry into the auto bank |
| fill_ifetch | output | 1 | Side of the fill |
| fill_vpn | output | VA_W-12 | Page number being filled |
| fill_way | output | WAY_W | Victim way in the indexed set |
| fill_pte | output | 32 | Entry word to install |
| restart | output | 1 | Retry the original access |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 4 | 1 instr miss, 2 data miss, 3 double, 4 access fault |

## Verification
The bench builds the engine with `SETS_LOG2`=2 and four ways. With only four sets, repeated fills to one set wrap its victim pointer past way 3 within a few misses. Neighbouring sets and the other side can then be checked for independence. The bench memory model's latency is varied from 0 to 3 cycles, so both a same-cycle acknowledge and a held request are exercised. A page number of all ones places the entry at the top of the 4 MiB table.

// File: rtl/pte_refill_pkg.sv
package pte_refill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_FETCH, ST_FILL, ST_RESUME, ST_TRAP
  } refill_state_t;

  localparam logic [3:0] EXC_NONE       = 4'd0;
  localparam logic [3:0] EXC_ITLB_MISS  = 4'd1;
  localparam logic [3:0] EXC_DTLB_MISS  = 4'd2;
  localparam logic [3:0] EXC_DOUBLE     = 4'd3;
  localparam logic [3:0] EXC_READ_FAULT = 4'd4;
endpackage

// File: rtl/pte_addr_calc.sv
module pte_addr_calc #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic [VA_W-1:0]            base,
  input  logic [VA_W-PAGE_SHIFT-1:0] vpn,
  output logic [VA_W-1:0]            entry_addr
);
  localparam int OFS_W = VA_W - PAGE_SHIFT + ENTRY_LOG2;

  logic [OFS_W-1:0] offset;

  // page number scaled by the entry size, i.e. VA >> 10 with low bits cleared
  assign offset     = {vpn, {ENTRY_LOG2{1'b0}}};
  assign entry_addr = base + VA_W'(offset);
endmodule

// File: rtl/pte_victim_rr.sv
module pte_victim_rr #(
  parameter int SETS_LOG2 = 3,
  parameter int WAYS      = 4,
  parameter int WAY_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 side,
  input  logic [SETS_LOG2-1:0] set_idx,
  output logic [WAY_W-1:0]     way
);
  localparam int SETS = 1 << SETS_LOG2;
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] cnt_q [2][SETS];

  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar k = 0; k < SETS; k++) begin : g_set
      logic             step;
      logic [WAY_W-1:0] cnt_d;

      always_comb begin
        step  = adv && (side == s[0]) && (set_idx == SETS_LOG2'(k));
        cnt_d = (cnt_q[s][k] == LAST_WAY) ? '0 : cnt_q[s][k] + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q[s][k] <= '0;
        else if (step) cnt_q[s][k] <= cnt_d;
      end
    end
  end

  assign way = cnt_q[side][set_idx];
endmodule

// File: rtl/pte_refill_ctrl.sv
module pte_refill_ctrl
  import pte_refill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       miss_valid,
  input  logic       side_ifetch,
  input  logic       excm,
  input  logic       lkup_hit,
  input  logic       mem_ack,
  input  logic       mem_err,
  output logic       accept,
  output logic       paddr_en,
  output logic       pte_en,
  output logic       busy,
  output logic       lkup_req,
  output logic       mem_req,
  output logic       fill_valid,
  output logic       restart,
  output logic       exc_valid,
  output logic [3:0] exc_code
);
  refill_state_t state_q, state_d;
  logic [3:0]    code_q, code_d;
  logic          code_en;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    code_en = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (miss_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (lkup_hit) begin
          state_d = ST_FETCH;
        end else begin
          state_d = ST_TRAP;
          code_en = 1'b1;
          if (excm)             code_d = EXC_DOUBLE;
          else if (side_ifetch) code_d = EXC_ITLB_MISS;
          else                  code_d = EXC_DTLB_MISS;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (mem_err) begin
            state_d = ST_TRAP;
            code_en = 1'b1;
            code_d  = EXC_READ_FAULT;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL:   state_d = ST_RESUME;
      ST_RESUME: state_d = ST_IDLE;
      ST_TRAP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= EXC_NONE;
    else if (code_en) code_q <= code_d;
  end

  always_comb begin
    accept     = (state_q == ST_IDLE) && miss_valid;
    paddr_en   = (state_q == ST_LOOKUP) && lkup_hit;
    pte_en     = (state_q == ST_FETCH) && mem_ack && !mem_err;
    busy       = (state_q != ST_IDLE);
    lkup_req   = (state_q == ST_LOOKUP);
    mem_req    = (state_q == ST_FETCH);
    fill_valid = (state_q == ST_FILL);
    restart    = (state_q == ST_RESUME);
    exc_valid  = (state_q == ST_TRAP);
    exc_code   = exc_valid ? code_q : EXC_NONE;
  end
endmodule

// File: rtl/pte_refill_engine.sv
module pte_refill_engine #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int SETS_LOG2 = 3,
  parameter int WAYS      = 4,
  localparam int VPN_W    = VA_W - 12,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic             miss_ifetch,
  input  logic             excm,
  input  logic [VA_W-1:0]  pt_base,
  output logic             busy,
  output logic             lkup_req,
  output logic [VA_W-1:0]  lkup_vaddr,
  output logic [1:0]       lkup_ring,
  input  logic             lkup_hit,
  input  logic [PA_W-1:0]  lkup_paddr,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  output logic             fill_valid,
  output logic             fill_ifetch,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [WAY_W-1:0] fill_way,
  output logic [31:0]      fill_pte,
  output logic             restart,
  output logic             exc_valid,
  output logic [3:0]       exc_code
);
  logic [VPN_W-1:0] vpn_q;
  logic             side_q;
  logic [PA_W-1:0]  paddr_q;
  logic [31:0]      pte_q;
  logic             accept, paddr_en, pte_en;

  pte_refill_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .side_ifetch(side_q),
    .excm       (excm),
    .lkup_hit   (lkup_hit),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .accept     (accept),
    .paddr_en   (paddr_en),
    .pte_en     (pte_en),
    .busy       (busy),
    .lkup_req   (lkup_req),
    .mem_req    (mem_req),
    .fill_valid (fill_valid),
    .restart    (restart),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code)
  );

  pte_addr_calc #(.VA_W(VA_W)) u_addr (
    .base      (pt_base),
    .vpn       (vpn_q),
    .entry_addr(lkup_vaddr)
  );

  pte_victim_rr #(.SETS_LOG2(SETS_LOG2), .WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (fill_valid),
    .side   (side_q),
    .set_idx(vpn_q[SETS_LOG2-1:0]),
    .way    (fill_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      side_q <= 1'b0;
    end else if (accept) begin
      vpn_q  <= miss_vpn;
      side_q <= miss_ifetch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        paddr_q <= '0;
    else if (paddr_en) paddr_q <= lkup_paddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pte_q <= '0;
    else if (pte_en) pte_q <= mem_rdata;
  end

  assign lkup_ring   = 2'b00;
  assign mem_addr    = paddr_q;
  assign fill_ifetch = side_q;
  assign fill_vpn    = vpn_q;
  assign fill_pte    = pte_q;
endmodule

// File: rtl/pte_refill_engine_chk.sv
module pte_refill_engine_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            lkup_req,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [PA_W-1:0] mem_addr,
  input logic            fill_valid,
  input logic            restart,
  input logic            exc_valid
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!lkup_req && !mem_req && !fill_valid && !restart && !exc_valid));

  p_fill_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (restart && !fill_valid && !exc_valid));

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  p_trap_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !busy);

  p_no_fill_on_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!fill_valid && !restart));
endmodule

bind pte_refill_engine pte_refill_engine_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/pte_refill_engine_bench.sv
module pte_refill_engine_bench;
  localparam int VA_W = 32, PA_W = 32, SL = 2, WAYS = 4;
  localparam int VPN_W = VA_W - 12;
  localparam logic [31:0] PA_OFS = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             miss_valid = 0, miss_ifetch = 0, excm = 0;
  logic [VPN_W-1:0] miss_vpn = '0;
  logic [VA_W-1:0]  pt_base = 32'hC000_0000;
  logic             busy, lkup_req, lkup_hit, mem_req, mem_ack, mem_err;
  logic [VA_W-1:0]  lkup_vaddr;
  logic [1:0]       lkup_ring;
  logic [PA_W-1:0]  lkup_paddr, mem_addr;
  logic [31:0]      mem_rdata, fill_pte;
  logic             fill_valid, fill_ifetch, restart, exc_valid;
  logic [VPN_W-1:0] fill_vpn;
  logic [1:0]       fill_way;
  logic [3:0]       exc_code;

  logic       tlb_hit_en = 1, mem_err_en = 0;
  logic [3:0] mem_lat = 0, mcnt;

  assign lkup_hit   = lkup_req && tlb_hit_en;
  assign lkup_paddr = lkup_vaddr + PA_OFS;
  assign mem_ack    = mem_req && (mcnt == mem_lat);
  assign mem_err    = mem_ack && mem_err_en;
  assign mem_rdata  = mem_addr ^ 32'h5A5A_0F0F;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mcnt <= 0;
    else if (!mem_req || mem_ack) mcnt <= 0;
    else mcnt <= mcnt + 1;

  pte_refill_engine #(.VA_W(VA_W), .PA_W(PA_W), .SETS_LOG2(SL), .WAYS(WAYS)) u_pte_refill_engine (.*);

  int n_checks = 0, n_err = 0;
  int rr [2][4];

  // observations of one miss
  int          reads, lookups;
  logic [31:0] o_lk, o_mem, o_pte, o_code;
  logic [1:0]  o_ring, o_way;
  logic [19:0] o_vpn;
  logic        o_side, o_fill, o_rs, o_rs_after_fill, o_exc, o_busy1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_miss(input logic [19:0] vpn, input logic ifs, input logic ex, input logic intrude);
    bit done = 0;
    reads = 0; lookups = 0; o_fill = 0; o_rs = 0; o_rs_after_fill = 0; o_exc = 0;
    o_lk = 'x; o_mem = 'x; o_code = 0;
    @(negedge clk);
    miss_valid = 1; miss_vpn = vpn; miss_ifetch = ifs; excm = ex;
    @(negedge clk);
    miss_valid = intrude; miss_vpn = vpn ^ 20'h00F0F;
    o_busy1 = busy;
    for (int i = 0; i < 40; i++) begin
      if (lkup_req) begin lookups++; o_lk = lkup_vaddr; o_ring = lkup_ring; end
      if (mem_req && mem_ack) begin reads++; o_mem = mem_addr; end
      if (fill_valid) begin o_fill = 1; o_pte = fill_pte; o_way = fill_way; o_vpn = fill_vpn; o_side = fill_ifetch; end
      if (restart) begin o_rs = 1; o_rs_after_fill = o_fill; end
      if (exc_valid) begin o_exc = 1; o_code = {28'd0, exc_code}; end
      if (!busy) begin done = 1; break; end
      @(negedge clk);
      miss_valid = 0;
    end
    miss_valid = 0; excm = 0;
    chk("R8", "miss completed", {31'd0, done}, 1);
  endtask

  task automatic expect_fill(input string tag, input logic [19:0] vpn, input logic ifs);
    logic [31:0] ea = pt_base + {10'd0, vpn, 2'b00};
    int w = rr[ifs][vpn[1:0]];
    rr[ifs][vpn[1:0]] = (w + 1) % WAYS;
    chk("R1", {tag, " entry addr"}, o_lk, ea);
    chk("R2", {tag, " one lookup"}, lookups, 1);
    chk("R2", {tag, " ring"}, {30'd0, o_ring}, 0);
    chk("R2", {tag, " read addr"}, o_mem, ea + PA_OFS);
    chk("R3", {tag, " read count"}, reads, 1);
    chk("R6", {tag, " pte"}, o_pte, (ea + PA_OFS) ^ 32'h5A5A_0F0F);
    chk("R6", {tag, " vpn"}, {12'd0, o_vpn}, {12'd0, vpn});
    chk("R6", {tag, " side"}, {31'd0, o_side}, {31'd0, ifs});
    chk("R6", {tag, " restart after fill"}, {30'd0, o_rs, o_rs_after_fill}, 3);
    chk("R6", {tag, " no exception"}, {31'd0, o_exc}, 0);
    chk("R7", {tag, " victim way"}, {30'd0, o_way}, w);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10", "outputs idle", {26'd0, busy, lkup_req, mem_req, fill_valid, restart, exc_valid}, 0);
  endtask

  task automatic t_data_refill;
    mem_lat = 0;
    run_miss(20'h12345, 0, 0, 0);
    chk("R8", "busy after accept", {31'd0, o_busy1}, 1);
    expect_fill("data", 20'h12345, 0);
  endtask

  task automatic t_instr_refill_slow;
    mem_lat = 3;
    run_miss(20'h00ABC, 1, 0, 0);
    expect_fill("instr", 20'h00ABC, 1);
    mem_lat = 0;
  endtask

  task automatic t_top_of_table;
    pt_base = 32'h8040_0000;
    run_miss(20'hFFFFF, 0, 0, 0);
    expect_fill("top entry", 20'hFFFFF, 0);
    chk("R1", "top entry offset", o_lk - pt_base, 32'h003F_FFFC);
    pt_base = 32'hC000_0000;
  endtask

  task automatic t_lookup_miss;
    tlb_hit_en = 0;
    run_miss(20'h00010, 0, 0, 0);
    chk("R4", "data miss code", o_code, 2);
    chk("R4", "data miss no read/fill", {reads[30:0], o_fill}, 0);
    run_miss(20'h00020, 1, 0, 0);
    chk("R4", "instr miss code", o_code, 1);
    chk("R4", "instr miss no read/fill", {reads[30:0], o_fill}, 0);
    tlb_hit_en = 1;
  endtask

  task automatic t_double;
    tlb_hit_en = 0;
    run_miss(20'h00030, 1, 1, 0);
    chk("R5", "double code instr", o_code, 3);
    run_miss(20'h00031, 0, 1, 0);
    chk("R5", "double code data", o_code, 3);
    chk("R5", "double no read", reads, 0);
    tlb_hit_en = 1;
  endtask

  task automatic t_read_error;
    mem_err_en = 1; mem_lat = 2;
    run_miss(20'h00040, 0, 0, 0);
    chk("R9", "fault code", o_code, 4);
    chk("R9", "no fill, no restart", {30'd0, o_fill, o_rs}, 0);
    mem_err_en = 0; mem_lat = 0;
  endtask

  task automatic t_round_robin;
    for (int n = 0; n < 5; n++) begin
      run_miss(20'h00100 + 20'(n * 4) + 20'd2, 0, 0, 0);
      expect_fill("rr set2", 20'h00100 + 20'(n * 4) + 20'd2, 0);
    end
    run_miss(20'h00203, 0, 0, 0);
    expect_fill("rr set3", 20'h00203, 0);
    run_miss(20'h00302, 1, 0, 0);
    expect_fill("rr instr set2", 20'h00302, 1);
  endtask

  task automatic t_busy_ignore;
    run_miss(20'h00501, 0, 0, 1);
    chk("R8", "intruding miss reads", reads, 1);
    chk("R8", "intruding miss vpn", {12'd0, o_vpn}, 32'h00501);
    rr[0][1] = (rr[0][1] + 1) % WAYS;
    @(negedge clk);
    chk("R8", "idle after intrusion", {31'd0, busy}, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) for (int k = 0; k < 4; k++) rr[s][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_data_refill();
    t_instr_refill_slow();
    t_top_of_table();
    t_lookup_miss();
    t_double();
    t_read_error();
    t_round_robin();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule